// File: doc/BRIEF.md
# Strobed Output Port with Buffer-Full Handshake

This block is one byte-wide output channel that hands data from a processor to an external device through a two-wire handshake. A processor write latches a byte onto the output pins and pulls an active-low buffer-full line low. The external device sees the line low, takes the byte, and pulses an active-low acknowledge. The falling edge of acknowledge releases buffer-full. When acknowledge has returned high and the interrupt-enable input is set, the block raises an interrupt request meaning "ready for the next byte". The next processor write clears that request.

The write strobe and the acknowledge are asynchronous to the block clock. Each passes through a synchronizer, and the block acts once per detected falling edge. A strobe held low does not act again. The latched byte stays on the pins until the next write, whatever happens on acknowledge or enable.

The data path has no ready signal. Back-pressure is the buffer-full line. The processor must see it high before it writes. A write while the line is low is not blocked: the new byte replaces the old one and the line stays low. The device must not acknowledge while the line is high; such an acknowledge is ignored.

Top module: `strobed_out_port`

## Requirements
- R1: After reset, `obf_n_o` is 1, `irq_o` is 0 and `pd_o` is 0x00.
- R2: A falling edge on `wr_n_i` latches `wr_data_i` onto `pd_o` and drives `obf_n_o` to 0. Both outputs show the change on the third rising clock edge after the strobe falls, and by five clocks at the latest.
- R3: A falling edge on `ack_n_i` while `obf_n_o` is 0 returns `obf_n_o` to 1 and leaves `pd_o` unchanged.
- R4: `irq_o` stays 0 while acknowledge is still low. It rises only after acknowledge has returned high after an acknowledge that emptied the buffer, and only while `irq_en_i` is 1.
- R5: `irq_o` follows `irq_en_i` as a level once the acknowledge has completed. Clearing the enable drops the request, and setting it again restores the request, with no new acknowledge.
- R6: A detected falling edge on `wr_n_i` clears `irq_o`.
- R7: `pd_o` changes only on a detected write edge. Acknowledges and enable changes leave it as it is.
- R8: An acknowledge falling edge while `obf_n_o` is 1 is ignored. `obf_n_o`, `irq_o` and `pd_o` keep their values.
- R9: When a write edge and an acknowledge edge are detected in the same cycle, the write wins. The new byte is latched, `obf_n_o` is 0 and `irq_o` stays 0.
- R10: Each strobe acts on one detected edge only. A write strobe held low does not reload the buffer after an acknowledge, and its rising edge does nothing.
- R11: A write while `obf_n_o` is already 0 replaces the byte on `pd_o` and keeps `obf_n_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| wr_n_i | input | 1 | Processor write strobe, active low, asynchronous |
| wr_data_i | input | 8 | Byte to be written, stable while the strobe is low |
| irq_en_i | input | 1 | Interrupt enable level |
| ack_n_i | input | 1 | Device acknowledge, active low, asynchronous |
| pd_o | output | 8 | Latched output byte to the device |
| obf_n_o | output | 1 | Output buffer full, active low |
| irq_o | output | 1 | Ready-for-next-byte interrupt request |

## Verification
The assertions check on every cycle that:
- a request never coexists with a full buffer;
- a detected write empties the request and fills the buffer on the next cycle;
- acknowledges move buffer-full only in the allowed direction;
- the output byte is stable except after a write edge;
- a cleared enable silences the request.

Only the bench's scenarios can show certain behaviours:
- the end-to-end latency through the synchronizers;
- that the request waits for acknowledge to return high;
- that the enable acts as a level;
- the write-over-acknowledge priority;
- that a strobe held low acts only once.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY  = 2'd0,
    ST_FULL   = 2'd1,
    ST_ACKING = 2'd2,
    ST_DONE   = 2'd3
  } hs_state_e;
endpackage

// File: rtl/sop_sync_edge.sv
// Synchronizes an asynchronous active-low strobe and flags its falling edge.
module sop_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          hist_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b1;
    else        hist_q <= chain_q[LAST];
  end

  assign level_o = chain_q[LAST];
  assign fall_o  = hist_q & ~chain_q[LAST];
endmodule

// File: rtl/sop_hs_ctrl.sv
// Handshake sequencer: empty -> full -> acknowledging -> done.
module sop_hs_ctrl
  import sop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fall_i,
  input  logic ack_fall_i,
  input  logic ack_lvl_i,
  input  logic irq_en_i,
  output logic load_o,
  output logic obf_n_o,
  output logic irq_o
);
  hs_state_e state_q, state_d;
  logic      obf_n_q, irq_q;

  always_comb begin
    state_d = state_q;
    if (wr_fall_i) begin
      state_d = ST_FULL;                 // write wins over any acknowledge
    end else begin
      unique case (state_q)
        ST_FULL:   if (ack_fall_i) state_d = ST_ACKING;
        ST_ACKING: if (ack_lvl_i)  state_d = ST_DONE;
        default:   state_d = state_q;    // acknowledges ignored when empty or done
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      obf_n_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      obf_n_q <= (state_d != ST_FULL);
      irq_q   <= (state_d == ST_DONE) && irq_en_i;
    end
  end

  assign load_o  = wr_fall_i;
  assign obf_n_o = obf_n_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/sop_out_latch.sv
// Output data latch that holds its value until the next load.
module sop_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              irq_en_i,
  input  logic              ack_n_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              obf_n_o,
  output logic              irq_o
);
  logic wr_lvl, wr_fall, ack_lvl, ack_fall, load;

  sop_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(wr_n_i),
    .level_o(wr_lvl), .fall_o(wr_fall)
  );

  sop_sync_edge #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ack_n_i),
    .level_o(ack_lvl), .fall_o(ack_fall)
  );

  sop_hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_fall_i(wr_fall), .ack_fall_i(ack_fall), .ack_lvl_i(ack_lvl),
    .irq_en_i(irq_en_i),
    .load_o(load), .obf_n_o(obf_n_o), .irq_o(irq_o)
  );

  sop_out_latch #(.WIDTH(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_i(load), .d_i(wr_data_i), .q_o(pd_o)
  );
endmodule

// File: rtl/strobed_out_port_chk.sv
module strobed_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_lvl,
  input logic              wr_fall,
  input logic              ack_fall,
  input logic              irq_en_i,
  input logic [DATA_W-1:0] pd_o,
  input logic              obf_n_o,
  input logic              irq_o
);
  // R4: a request means the buffer has been emptied
  assert_irq_only_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> obf_n_o);

  // R2, R6: a detected write fills the buffer and drops the request
  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> (!obf_n_o && !irq_o));

  // R3: an acknowledge on a full buffer empties it
  assert_ack_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !wr_fall && !obf_n_o) |=> obf_n_o);

  // R8: an acknowledge on an empty buffer keeps it empty
  assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !wr_fall && obf_n_o) |=> obf_n_o);

  // R7: the output byte moves only after a write edge
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fall |=> $stable(pd_o));

  // R5: no request while the enable is clear
  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |=> !irq_o);

  // R10: a write edge is seen only while the synchronized strobe is low
  assert_single_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> !wr_fall);

  assert_fall_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |-> !wr_lvl);
endmodule

bind strobed_out_port strobed_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lvl(wr_lvl), .wr_fall(wr_fall),
  .ack_fall(ack_fall), .irq_en_i(irq_en_i), .pd_o(pd_o),
  .obf_n_o(obf_n_o), .irq_o(irq_o)
);

// File: tb/strobed_out_port_tb_top.sv
`timescale 1ns/1ps
module strobed_out_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       irq_en = 1'b0;
  logic       ack_n = 1'b1;
  logic [7:0] pd;
  logic       obf_n, irq;

  int  tests_run = 0;
  int  tests_failed = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  strobed_out_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n_i(wr_n), .wr_data_i(wr_data),
    .irq_en_i(irq_en), .ack_n_i(ack_n),
    .pd_o(pd), .obf_n_o(obf_n), .irq_o(irq)
  );

  // op[19:18] 0=write arg, 1=ack pulse, 2=set enable arg[0];
  // arg[17:10], expected pd[9:2], expected obf_n[1], expected irq[0]
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {2'd2, 8'h01, 8'h00, 1'b1, 1'b0},  // R8 state: enable with nothing sent
    {2'd0, 8'hA5, 8'hA5, 1'b0, 1'b0},  // R2
    {2'd1, 8'h00, 8'hA5, 1'b1, 1'b1},  // R3 R4
    {2'd0, 8'h3C, 8'h3C, 1'b0, 1'b0},  // R6
    {2'd1, 8'h00, 8'h3C, 1'b1, 1'b1},  // R4
    {2'd2, 8'h00, 8'h3C, 1'b1, 1'b0},  // R5
    {2'd2, 8'h01, 8'h3C, 1'b1, 1'b1},  // R5
    {2'd1, 8'h00, 8'h3C, 1'b1, 1'b1},  // R8
    {2'd0, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R6
    {2'd0, 8'h81, 8'h81, 1'b0, 1'b0},  // R11
    {2'd2, 8'h00, 8'h81, 1'b0, 1'b0},  // R7
    {2'd1, 8'h00, 8'h81, 1'b1, 1'b0},  // R5
    {2'd2, 8'h01, 8'h81, 1'b1, 1'b1},  // R5
    {2'd0, 8'h00, 8'h00, 1'b0, 1'b0}   // R2
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_n = 1'b0;
    wait_n(6);
    wr_n = 1'b1;
    wait_n(6);
  endtask

  task automatic do_ack();
    @(negedge clk); ack_n = 1'b0;
    wait_n(6);
    ack_n = 1'b1;
    wait_n(6);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_n = 1'b1; ack_n = 1'b1; irq_en = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
  endtask

  initial begin
    do_reset();
    chk("R1 obf_n", {7'd0, obf_n}, 8'h01);
    chk("R1 irq",   {7'd0, irq},   8'h00);
    chk("R1 pd",    pd,            8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      case (v[19:18])
        2'd0: do_write(v[17:10]);
        2'd1: do_ack();
        default: begin
          @(negedge clk); irq_en = v[10];
          wait_n(3);
        end
      endcase
      chk($sformatf("vec%0d pd",    i), pd,            v[9:2]);
      chk($sformatf("vec%0d obf_n", i), {7'd0, obf_n}, {7'd0, v[1]});
      chk($sformatf("vec%0d irq",   i), {7'd0, irq},   {7'd0, v[0]});
    end

    // R2: latency of three clocks through the synchronizer
    do_reset();
    @(negedge clk); wr_data = 8'h6B; wr_n = 1'b0;
    wait_n(2);
    chk("R2 obf_n before third edge", {7'd0, obf_n}, 8'h01);
    wait_n(1);
    chk("R2 obf_n at third edge", {7'd0, obf_n}, 8'h00);
    chk("R2 pd at third edge", pd, 8'h6B);
    wr_n = 1'b1;
    wait_n(4);

    // R4: no request while acknowledge is still low
    irq_en = 1'b1;
    @(negedge clk); ack_n = 1'b0;
    wait_n(6);
    chk("R4 obf_n during ack", {7'd0, obf_n}, 8'h01);
    chk("R4 irq during ack",   {7'd0, irq},   8'h00);
    ack_n = 1'b1;
    wait_n(6);
    chk("R4 irq after ack",    {7'd0, irq},   8'h01);

    // R8: acknowledge right after reset is ignored
    do_reset();
    irq_en = 1'b1;
    do_ack();
    chk("R8 obf_n",  {7'd0, obf_n}, 8'h01);
    chk("R8 irq",    {7'd0, irq},   8'h00);
    chk("R8 pd",     pd,            8'h00);

    // R9: write and acknowledge edges in the same cycle
    do_write(8'h11);
    @(negedge clk); wr_data = 8'h5A; wr_n = 1'b0; ack_n = 1'b0;
    wait_n(6);
    wr_n = 1'b1; ack_n = 1'b1;
    wait_n(6);
    chk("R9 pd",    pd,            8'h5A);
    chk("R9 obf_n", {7'd0, obf_n}, 8'h00);
    chk("R9 irq",   {7'd0, irq},   8'h00);

    // R10: a write strobe held low acts once
    do_reset();
    irq_en = 1'b1;
    @(negedge clk); wr_data = 8'h77; wr_n = 1'b0;
    wait_n(6);
    chk("R10 obf_n loaded", {7'd0, obf_n}, 8'h00);
    do_ack();
    wait_n(20);
    chk("R10 obf_n stays empty", {7'd0, obf_n}, 8'h01);
    chk("R10 irq raised",        {7'd0, irq},   8'h01);
    @(negedge clk); wr_data = 8'h99; wr_n = 1'b1;
    wait_n(6);
    chk("R10 rising strobe obf_n", {7'd0, obf_n}, 8'h01);
    chk("R10 rising strobe pd",    pd,            8'h77);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule